// File: doc/BRIEF.md
# DDR Write Datapath with Strobe Preamble

This block is the write half of a double-data-rate memory port. Each clock cycle in which core logic raises `wr_en`, it accepts a pair of words and a pair of byte-mask vectors. It sends the high word and then the low word onto the data pins, one per half cycle, so the pins run at twice the clock rate. Data and mask are launched from `wclk`, a copy of the system clock delayed by a quarter period. That places each data beat across a strobe edge.

The strobe is launched from the system clock and toggles once per burst cycle. Its output enable goes through two registers: one updates on the rising clock edge and one samples it half a cycle later. Their AND holds the strobe pin in high impedance for an extra half cycle. The strobe is then driven low for one full clock before its first rising edge (the write preamble). After the last falling edge it is held low for one more clock (the postamble) before release.

All enables are active low. Each 8-bit byte lane has its own strobe, strobe enable and mask pin.

Top module: `ddr_wr_datapath`

## Requirements
- R1: While `rst_n` is low, `dq_oe_n` is 1, every `dqs_oe_n` bit is 1 and every `dqs_out` bit is 0.
- R2: Once `wr_en` has been low for at least three clock cycles, `dq_oe_n` and every `dqs_oe_n` bit stay 1 and the strobe makes no edge. Data and mask inputs have no effect during that time.
- R3: Each rising `clk` edge that samples `wr_en` high accepts one word pair. `wdata_hi` reaches `dq_out` before `wdata_lo`. Consecutive accepted cycles produce an unbroken stream of beats, and every accepted word is delivered exactly once.
- R4: The high word is driven while `wclk` is high and the low word while `wclk` is low. Driving starts at the second `wclk` rising edge after the sampling `clk` edge. `dq_oe_n` is 0 during every beat.
- R5: For each accepted pair, the strobe is low while `clk` is high and high while `clk` is low. Its rising edge comes 1.5 clock periods after the sampling edge, and all lanes carry the same strobe. The high word is the beat around the rising strobe edge and the low word the beat around the falling edge.
- R6: `dqs_oe_n` falls exactly one clock period before the first rising strobe edge of a burst, half a cycle after the first enable register asserts. The strobe is low throughout this preamble.
- R7: `dqs_oe_n` returns to 1 exactly one clock period after the last falling strobe edge of a burst, and the strobe stays low in between.
- R8: `dm_out[g]` carries the mask bit of the beat on the data pins, with the same timing as the data. 0 means byte bits [8g+7:8g] are written and 1 means they are masked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; launches the strobe and its enable |
| wclk | input | 1 | Write clock, `clk` delayed by a quarter period; launches data and mask |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Accept one word pair at this clock edge |
| wdata_hi | input | DATA_W | Word sent first in the cycle |
| wdata_lo | input | DATA_W | Word sent second in the cycle |
| wmask_hi | input | DATA_W/8 | Byte masks for the first word (1 = masked) |
| wmask_lo | input | DATA_W/8 | Byte masks for the second word (1 = masked) |
| dq_out | output | DATA_W | Double-rate data pin values |
| dq_oe_n | output | 1 | Active-low enable for data and mask pins |
| dm_out | output | DATA_W/8 | Double-rate byte mask pin values |
| dqs_out | output | DATA_W/8 | Strobe value per byte lane |
| dqs_oe_n | output | DATA_W/8 | Active-low strobe enable per byte lane |

## Verification
Word pairs pass through two system-clock stages and one write-clock register. A pair sampled at a rising edge S therefore appears on the data pins from S+1.25 periods and is centred on strobe edges at S+1.5 and S+2 periods. The strobe enable falls at S+0.5 periods and is released one period after the last falling strobe edge. The bench samples data, mask and enables 1 ns after each strobe edge, well inside the 4 ns beat. It times the preamble and postamble against the enable transitions, and it compares the first rising strobe edge of each burst with a time computed when the burst was driven. Inputs change on falling `clk` edges, away from every capturing edge.

// File: rtl/ddr_wr_datapath.sv
`timescale 1ns/1ps
module ddr_wr_datapath #(
  parameter int DATA_W = 16,
  parameter int LANE_W = 8,
  localparam int LANES = DATA_W / LANE_W
) (
  input  logic              clk,
  input  logic              wclk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata_hi,
  input  logic [DATA_W-1:0] wdata_lo,
  input  logic [LANES-1:0]  wmask_hi,
  input  logic [LANES-1:0]  wmask_lo,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe_n,
  output logic [LANES-1:0]  dm_out,
  output logic [LANES-1:0]  dqs_out,
  output logic [LANES-1:0]  dqs_oe_n
);

  logic              s_en, s2_en;
  logic [DATA_W-1:0] s_hi, s_lo, s2_hi, s2_lo;
  logic [LANES-1:0]  s_mhi, s_mlo, s2_mhi, s2_mlo;

  logic [DATA_W-1:0] q_hi, q_lo;
  logic [LANES-1:0]  m_hi, m_lo;
  logic              qoe_h, qoe_l;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_en   <= 1'b0;
      s2_en  <= 1'b0;
      s_hi   <= '0;
      s_lo   <= '0;
      s2_hi  <= '0;
      s2_lo  <= '0;
      s_mhi  <= '1;
      s_mlo  <= '1;
      s2_mhi <= '1;
      s2_mlo <= '1;
    end else begin
      s_en   <= wr_en;
      s_hi   <= wdata_hi;
      s_lo   <= wdata_lo;
      s_mhi  <= wmask_hi;
      s_mlo  <= wmask_lo;
      s2_en  <= s_en;
      s2_hi  <= s_hi;
      s2_lo  <= s_lo;
      s2_mhi <= s_mhi;
      s2_mlo <= s_mlo;
    end
  end

  // quarter-period-late launch: both halves load together, the clock level picks one
  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      q_hi  <= '0;
      q_lo  <= '0;
      m_hi  <= '1;
      m_lo  <= '1;
      qoe_h <= 1'b0;
      qoe_l <= 1'b0;
    end else begin
      q_hi  <= s2_hi;
      q_lo  <= s2_lo;
      m_hi  <= s2_mhi;
      m_lo  <= s2_mlo;
      qoe_h <= s2_en;
      qoe_l <= s2_en;
    end
  end

  assign dq_out  = wclk ? q_hi : q_lo;
  assign dm_out  = wclk ? m_hi : m_lo;
  assign dq_oe_n = ~(wclk ? qoe_h : qoe_l);

  AST_DATA_IDLE_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    !s2_en |-> dq_oe_n); // R2

  AST_DATA_HAS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !dq_oe_n |-> !dqs_oe_n[0]); // R4

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic oe_rise_r, oe_fall_r, stb_r;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        oe_rise_r <= 1'b0;
        stb_r     <= 1'b0;
      end else begin
        oe_rise_r <= wr_en | s_en | s2_en;
        stb_r     <= s_en;
      end
    end

    // half-cycle-late copy: keeps the pin released for one more half period
    always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) oe_fall_r <= 1'b0;
      else        oe_fall_r <= oe_rise_r;
    end

    assign dqs_out[g]  = clk ? 1'b0 : stb_r;
    assign dqs_oe_n[g] = ~(oe_rise_r & oe_fall_r);

    AST_PREAMBLE_HIZ: assert property (@(negedge clk) disable iff (!rst_n)
      $rose(oe_rise_r) |-> dqs_oe_n[g]); // R6

    AST_STROBE_HIGH_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
      dqs_out[g] |-> !dqs_oe_n[g]); // R5

    AST_POSTAMBLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(s2_en) |-> (!dqs_oe_n[g] && !dqs_out[g])); // R7
  end

endmodule

// File: tb/ddr_wr_datapath_tb_top.sv
`timescale 1ns/1ps
module ddr_wr_datapath_tb_top;
  localparam int DATA_W = 16;
  localparam int LANES  = DATA_W / 8;

  logic clk = 1'b0, wclk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [DATA_W-1:0] wdata_hi = '0, wdata_lo = '0;
  logic [LANES-1:0]  wmask_hi = '0, wmask_lo = '0;
  logic [DATA_W-1:0] dq_out;
  logic              dq_oe_n;
  logic [LANES-1:0]  dm_out, dqs_out, dqs_oe_n;

  ddr_wr_datapath #(.DATA_W(DATA_W), .LANE_W(8)) dut_i (
    .clk(clk), .wclk(wclk), .rst_n(rst_n), .wr_en(wr_en),
    .wdata_hi(wdata_hi), .wdata_lo(wdata_lo),
    .wmask_hi(wmask_hi), .wmask_lo(wmask_lo),
    .dq_out(dq_out), .dq_oe_n(dq_oe_n), .dm_out(dm_out),
    .dqs_out(dqs_out), .dqs_oe_n(dqs_oe_n));

  always #4 clk = ~clk;
  initial begin #2; forever #4 wclk = ~wclk; end

  typedef struct packed {
    logic [DATA_W-1:0] d;
    logic [LANES-1:0]  m;
    logic              r;
  } beat_t;

  beat_t   exp_q[$];
  realtime rise_q[$];
  realtime last_fall = 0;
  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic send(input logic [DATA_W-1:0] hi, input logic [DATA_W-1:0] lo,
                      input logic [LANES-1:0] mhi, input logic [LANES-1:0] mlo);
    @(negedge clk);
    if (!wr_en) rise_q.push_back($realtime + 16.0);
    wr_en = 1'b1; wdata_hi = hi; wdata_lo = lo; wmask_hi = mhi; wmask_lo = mlo;
    exp_q.push_back('{d: hi, m: mhi, r: 1'b1});
    exp_q.push_back('{d: lo, m: mlo, r: 1'b0});
  endtask

  task automatic idle(input int n, input bit junk, input bit check);
    repeat (n) begin
      @(negedge clk);
      wr_en = 1'b0;
      if (junk) begin
        wdata_hi = DATA_W'($urandom); wdata_lo = DATA_W'($urandom);
        wmask_hi = LANES'($urandom);  wmask_lo = LANES'($urandom);
      end
      if (check) begin
        #1;
        chk(dq_oe_n === 1'b1, "R2 data enable idle", dq_oe_n, 1);
        chk(dqs_oe_n === '1, "R2 strobe enable idle", dqs_oe_n, '1);
      end
    end
  endtask

  // scoreboard monitor: one expected beat per strobe edge
  initial begin
    wait (rst_n === 1'b1);
    forever begin
      bit e; realtime te; beat_t b;
      @(dqs_out[0]);
      e = dqs_out[0]; te = $realtime;
      #1;
      if (!e) last_fall = te;
      if (exp_q.size() == 0) chk(1'b0, "R2 unexpected strobe edge", e, 0);
      else begin
        b = exp_q.pop_front();
        chk(e === b.r, "R5 strobe edge polarity", e, b.r);
        chk(dq_out === b.d, b.r ? "R3 R4 first word on rising edge" : "R3 R4 second word on falling edge", dq_out, b.d);
        chk(dm_out === b.m, "R8 mask bits with beat", dm_out, b.m);
        chk(dq_oe_n === 1'b0, "R4 data enabled during beat", dq_oe_n, 0);
        chk(dqs_oe_n === '0, "R5 strobe enabled during beat", dqs_oe_n, '0);
        chk(dqs_out === {LANES{e}}, "R5 lanes carry same strobe", dqs_out, {LANES{e}});
      end
    end
  end

  // preamble timing
  initial begin
    wait (rst_n === 1'b1);
    forever begin
      realtime t0;
      @(negedge dqs_oe_n[0]);
      t0 = $realtime;
      #1 chk(dqs_out === '0, "R6 strobe low early in preamble", dqs_out, 0);
      #4 chk(dqs_out === '0, "R6 strobe low late in preamble", dqs_out, 0);
      @(posedge dqs_out[0]);
      chk(int'($realtime - t0) == 8, "R6 preamble length ns", int'($realtime - t0), 8);
      if (rise_q.size() != 0) begin
        realtime er;
        er = rise_q.pop_front();
        chk(int'($realtime) == int'(er), "R5 first rising strobe time", int'($realtime), int'(er));
      end
    end
  end

  // postamble timing
  initial begin
    wait (rst_n === 1'b1);
    forever begin
      @(posedge dqs_oe_n[0]);
      chk(int'($realtime - last_fall) == 8, "R7 postamble length ns", int'($realtime - last_fall), 8);
    end
  end

  initial begin
    #(200000 * 8);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=end of stimulus");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(dq_oe_n === 1'b1, "R1 data enable in reset", dq_oe_n, 1);
    chk(dqs_oe_n === '1, "R1 strobe enable in reset", dqs_oe_n, '1);
    chk(dqs_out === '0, "R1 strobe low in reset", dqs_out, 0);
    #3;
    chk(dqs_out === '0, "R1 strobe low in reset other half", dqs_out, 0);
    @(negedge clk) rst_n = 1'b1;
    idle(3, 1'b0, 1'b1);

    send(16'hA5A5, 16'h5A5A, 2'b00, 2'b00);
    idle(6, 1'b0, 1'b0);

    send(16'h1111, 16'h2222, 2'b00, 2'b00);
    send(16'h3333, 16'h4444, 2'b00, 2'b00);
    idle(6, 1'b0, 1'b0);

    send(16'hDEAD, 16'hBEEF, 2'b11, 2'b01);
    send(16'hCAFE, 16'hF00D, 2'b10, 2'b00);
    send(16'h0000, 16'hFFFF, 2'b01, 2'b10);
    send(16'h8001, 16'h7FFE, 2'b00, 2'b11);
    idle(6, 1'b0, 1'b0);

    idle(10, 1'b1, 1'b1);

    for (int k = 0; k < 8; k++)
      send(DATA_W'(1) << (2 * k), DATA_W'(1) << (2 * k + 1), LANES'(k), LANES'(~k));
    idle(8, 1'b0, 1'b0);

    chk(exp_q.size() == 0, "R3 every beat delivered", exp_q.size(), 0);
    chk(rise_q.size() == 0, "R6 every burst had a preamble", rise_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule